// File: doc/BRIEF.md
# MII Carrier Sense, Collision and Receive-Valid Generator

This block produces the three media-status outputs of a 10/100 Mb/s media-independent interface: carrier sense, collision and receive data valid. It watches a transmit-active flag and a receive-non-idle flag, plus framing strobes from the receive decoder. It then forms registered status outputs, clocked by the MII reference clock (25 MHz at 100 Mb/s, 2.5 MHz at 10 Mb/s).

Carrier sense covers both directions in normal operation and only the receive direction in repeater operation. Collision is the overlap of transmit and receive activity in half duplex. At 10 Mb/s in half duplex, a heartbeat (SQE test) window also appears on the collision output after each transmission ends. Receive-valid opens on the first preamble nibble at 100 Mb/s and on the start-of-frame delimiter at 10 Mb/s. In isolate mode every output enable drops, so the pads float.

Top module: `mii_status_gen`

## Requirements
- R1: When repeater mode is off, `crs` equals `tx_active | rx_nonidle` sampled at the previous rising edge.
- R2: When repeater mode is on, `crs` equals `rx_nonidle` sampled at the previous rising edge, and transmit activity alone leaves `crs` low.
- R3: In half duplex, `col` is high one edge after `tx_active` and `rx_nonidle` are sampled high together. In full duplex, `col` is low one edge after any sample.
- R4: At 10 Mb/s (`speed_100`=0) in half duplex, suppose `tx_end_strobe` is sampled high at edge 0 while no heartbeat is pending. Then `col` is high after edges SQE_DELAY+1 through SQE_DELAY+SQE_WIDTH, and low again after edge SQE_DELAY+SQE_WIDTH+1.
- R5: A `tx_end_strobe` sampled while a heartbeat is already pending or running has no effect. A strobe at 100 Mb/s (`speed_100`=1), or in full duplex, starts no heartbeat: `col` stays low.
- R6: At 100 Mb/s, `rx_dv` goes high one edge after `rx_pre_start` is sampled. `rx_sfd` has no effect on `rx_dv`.
- R7: At 10 Mb/s, `rx_dv` goes high one edge after `rx_sfd` is sampled. `rx_pre_start` has no effect on `rx_dv`.
- R8: `rx_dv` goes low one edge after `rx_last` is sampled high. `rx_last` wins over a start event in the same cycle. With no event, `rx_dv` holds its value.
- R9: `crs_oe`, `col_oe` and `rx_dv_oe` equal the inverse of `isolate` sampled at the previous rising edge.
- R10: While `rst_n` is low, all six outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | 1 = full duplex |
| repeater_mode | input | 1 | 1 = carrier sense from the receiver only |
| isolate | input | 1 | 1 = release all outputs |
| tx_active | input | 1 | Transmitter non-idle |
| rx_nonidle | input | 1 | Receiver non-idle |
| rx_pre_start | input | 1 | Strobe on the first preamble nibble |
| rx_sfd | input | 1 | Strobe on start-of-frame delimiter detection |
| rx_last | input | 1 | Strobe after the last data nibble is delivered |
| tx_end_strobe | input | 1 | Strobe at the end of a transmission |
| crs | output | 1 | Carrier sense |
| crs_oe | output | 1 | Output enable for crs |
| col | output | 1 | Collision / heartbeat |
| col_oe | output | 1 | Output enable for col |
| rx_dv | output | 1 | Receive data valid |
| rx_dv_oe | output | 1 | Output enable for rx_dv |

## Verification
Carrier sense, the collision overlap, receive-valid and the enables all appear one rising edge after their inputs are sampled. The heartbeat on `col` arrives SQE_DELAY+1 edges after the strobe edge and lasts SQE_WIDTH edges. The driver computes the due cycle of each expected value from these delays and queues it with a mask. The monitor compares each entry at the falling edge of its due cycle, so no sample lands on the active edge. The heartbeat case queues its whole window in advance, including the cycles after a retrigger strobe, which must stay low.

// File: rtl/mii_status_pkg.sv
package mii_status_pkg;

   typedef enum logic [1:0] {
      HB_IDLE  = 2'd0,
      HB_WAIT  = 2'd1,
      HB_BURST = 2'd2
   } hb_state_e;

   localparam int unsigned N_STAT  = 3;
   localparam int unsigned IDX_CRS = 0;
   localparam int unsigned IDX_COL = 1;
   localparam int unsigned IDX_DV  = 2;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mii_carrier_col.sv
module mii_carrier_col (
   input  logic tx_active,
   input  logic rx_nonidle,
   input  logic repeater_mode,
   input  logic full_duplex,
   input  logic hb_active,
   output logic crs_d,
   output logic col_d
);
   logic overlap;

   always_comb begin
      overlap = tx_active & rx_nonidle;
      if (repeater_mode) begin
         crs_d = rx_nonidle;
      end else begin
         crs_d = tx_active | rx_nonidle;
      end
      col_d = ~full_duplex & (overlap | hb_active);
   end
endmodule

// File: rtl/mii_hb_timer.sv
module mii_hb_timer
   import mii_status_pkg::*;
#(
   parameter int unsigned DELAY = 4,
   parameter int unsigned WIDTH = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic strobe,
   output logic active
);
   localparam int unsigned SPAN  = max_u(DELAY, WIDTH);
   localparam int unsigned CNT_W = (SPAN > 1) ? $clog2(SPAN) : 1;
   localparam logic [CNT_W-1:0] LOAD_WAIT  = CNT_W'(DELAY - 1);
   localparam logic [CNT_W-1:0] LOAD_BURST = CNT_W'(WIDTH - 1);

   hb_state_e        state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             cnt_zero;

   assign cnt_zero = (cnt_q == '0);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      if (!enable) begin
         state_d = HB_IDLE;
         cnt_d   = '0;
      end else begin
         unique case (state_q)
            HB_IDLE: begin
               if (strobe) begin
                  state_d = HB_WAIT;
                  cnt_d   = LOAD_WAIT;
               end
            end
            HB_WAIT: begin
               if (cnt_zero) begin
                  state_d = HB_BURST;
                  cnt_d   = LOAD_BURST;
               end else begin
                  cnt_d = cnt_q - 1'b1;
               end
            end
            HB_BURST: begin
               if (cnt_zero) begin
                  state_d = HB_IDLE;
               end else begin
                  cnt_d = cnt_q - 1'b1;
               end
            end
            default: begin
               state_d = HB_IDLE;
               cnt_d   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= HB_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign active = (state_q == HB_BURST);
endmodule

// File: rtl/mii_rxdv_ctrl.sv
module mii_rxdv_ctrl (
   input  logic speed_100,
   input  logic rx_pre_start,
   input  logic rx_sfd,
   input  logic rx_last,
   input  logic dv_q,
   output logic dv_d
);
   logic open_evt;

   always_comb begin
      open_evt = speed_100 ? rx_pre_start : rx_sfd;
      if (rx_last) begin
         dv_d = 1'b0;
      end else if (open_evt) begin
         dv_d = 1'b1;
      end else begin
         dv_d = dv_q;
      end
   end
endmodule

// File: rtl/mii_out_stage.sv
module mii_out_stage #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   input  logic         isolate,
   output logic [N-1:0] q,
   output logic [N-1:0] oe
);
   for (genvar i = 0; i < N; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[i]  <= 1'b0;
            oe[i] <= 1'b0;
         end else begin
            q[i]  <= d[i];
            oe[i] <= ~isolate;
         end
      end
   end
endmodule

// File: rtl/mii_status_gen.sv
module mii_status_gen
   import mii_status_pkg::*;
#(
   parameter int unsigned SQE_DELAY = 4,
   parameter int unsigned SQE_WIDTH = 10,
   parameter bit          SQE_EN    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic speed_100,
   input  logic full_duplex,
   input  logic repeater_mode,
   input  logic isolate,
   input  logic tx_active,
   input  logic rx_nonidle,
   input  logic rx_pre_start,
   input  logic rx_sfd,
   input  logic rx_last,
   input  logic tx_end_strobe,
   output logic crs,
   output logic crs_oe,
   output logic col,
   output logic col_oe,
   output logic rx_dv,
   output logic rx_dv_oe
);
   if (SQE_DELAY < 1) begin : g_bad_delay
      $error("SQE_DELAY must be at least 1");
   end
   if (SQE_WIDTH < 1) begin : g_bad_width
      $error("SQE_WIDTH must be at least 1");
   end

   logic              hb_active;
   logic              crs_d, col_d, dv_d;
   logic [N_STAT-1:0] stat_d, stat_q, stat_oe;

   if (SQE_EN) begin : g_hb
      mii_hb_timer #(
         .DELAY(SQE_DELAY),
         .WIDTH(SQE_WIDTH)
      ) u_hb (
         .clk   (clk),
         .rst_n (rst_n),
         .enable(~speed_100 & ~full_duplex),
         .strobe(tx_end_strobe),
         .active(hb_active)
      );
   end else begin : g_no_hb
      assign hb_active = 1'b0;
   end

   mii_carrier_col u_cc (
      .tx_active    (tx_active),
      .rx_nonidle   (rx_nonidle),
      .repeater_mode(repeater_mode),
      .full_duplex  (full_duplex),
      .hb_active    (hb_active),
      .crs_d        (crs_d),
      .col_d        (col_d)
   );

   mii_rxdv_ctrl u_dv (
      .speed_100   (speed_100),
      .rx_pre_start(rx_pre_start),
      .rx_sfd      (rx_sfd),
      .rx_last     (rx_last),
      .dv_q        (stat_q[IDX_DV]),
      .dv_d        (dv_d)
   );

   always_comb begin
      stat_d          = '0;
      stat_d[IDX_CRS] = crs_d;
      stat_d[IDX_COL] = col_d;
      stat_d[IDX_DV]  = dv_d;
   end

   mii_out_stage #(.N(N_STAT)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (stat_d),
      .isolate(isolate),
      .q      (stat_q),
      .oe     (stat_oe)
   );

   assign crs      = stat_q[IDX_CRS];
   assign col      = stat_q[IDX_COL];
   assign rx_dv    = stat_q[IDX_DV];
   assign crs_oe   = stat_oe[IDX_CRS];
   assign col_oe   = stat_oe[IDX_COL];
   assign rx_dv_oe = stat_oe[IDX_DV];
endmodule

// File: rtl/mii_status_gen_chk.sv
module mii_status_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic speed_100,
   input logic full_duplex,
   input logic repeater_mode,
   input logic isolate,
   input logic tx_active,
   input logic rx_nonidle,
   input logic rx_pre_start,
   input logic rx_sfd,
   input logic rx_last,
   input logic crs,
   input logic crs_oe,
   input logic col,
   input logic col_oe,
   input logic rx_dv,
   input logic rx_dv_oe
);
   a_r1_crs_both: assert property (@(posedge clk) disable iff (!rst_n)
      !repeater_mode |=> crs == $past(tx_active | rx_nonidle));

   a_r2_crs_rx_only: assert property (@(posedge clk) disable iff (!rst_n)
      repeater_mode |=> crs == $past(rx_nonidle));

   a_r3_col_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_duplex && tx_active && rx_nonidle) |=> col);

   a_r3_col_fdx_low: assert property (@(posedge clk) disable iff (!rst_n)
      full_duplex |=> !col);

   a_r6_dv_open_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (speed_100 && rx_pre_start && !rx_last) |=> rx_dv);

   a_r7_dv_open_slow: assert property (@(posedge clk) disable iff (!rst_n)
      (!speed_100 && rx_sfd && !rx_last) |=> rx_dv);

   a_r7_pre_ignored_slow: assert property (@(posedge clk) disable iff (!rst_n)
      (!speed_100 && !rx_dv && !rx_sfd) |=> !rx_dv);

   a_r8_dv_close: assert property (@(posedge clk) disable iff (!rst_n)
      rx_last |=> !rx_dv);

   a_r9_oe_follow: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (crs_oe == !$past(isolate)) && (col_oe == !$past(isolate))
               && (rx_dv_oe == !$past(isolate)));

   always_comb begin
      if (!rst_n) begin
         a_r10_reset_low: assert (!crs && !col && !rx_dv && !crs_oe && !col_oe && !rx_dv_oe
                                  || $time == 0);
      end
   end
endmodule

bind mii_status_gen mii_status_gen_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .speed_100    (speed_100),
   .full_duplex  (full_duplex),
   .repeater_mode(repeater_mode),
   .isolate      (isolate),
   .tx_active    (tx_active),
   .rx_nonidle   (rx_nonidle),
   .rx_pre_start (rx_pre_start),
   .rx_sfd       (rx_sfd),
   .rx_last      (rx_last),
   .crs          (crs),
   .crs_oe       (crs_oe),
   .col          (col),
   .col_oe       (col_oe),
   .rx_dv        (rx_dv),
   .rx_dv_oe     (rx_dv_oe)
);

// File: tb/mii_status_gen_tb.sv
module mii_status_gen_tb;
   localparam int unsigned D = 4;
   localparam int unsigned W = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic speed_100 = 1'b1, full_duplex = 1'b0, repeater_mode = 1'b0, isolate = 1'b0;
   logic tx_active = 1'b0, rx_nonidle = 1'b0;
   logic rx_pre_start = 1'b0, rx_sfd = 1'b0, rx_last = 1'b0, tx_end_strobe = 1'b0;
   logic crs, crs_oe, col, col_oe, rx_dv, rx_dv_oe;

   always #5 clk = ~clk;

   mii_status_gen #(.SQE_DELAY(D), .SQE_WIDTH(W), .SQE_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .full_duplex(full_duplex),
      .repeater_mode(repeater_mode), .isolate(isolate), .tx_active(tx_active),
      .rx_nonidle(rx_nonidle), .rx_pre_start(rx_pre_start), .rx_sfd(rx_sfd),
      .rx_last(rx_last), .tx_end_strobe(tx_end_strobe), .crs(crs), .crs_oe(crs_oe),
      .col(col), .col_oe(col_oe), .rx_dv(rx_dv), .rx_dv_oe(rx_dv_oe)
   );

   // bit order: crs, col, rx_dv, crs_oe, col_oe, rx_dv_oe
   localparam logic [5:0] M_ALL = 6'b111111;
   localparam logic [5:0] M_CRS = 6'b100000;
   localparam logic [5:0] M_COL = 6'b010000;
   localparam logic [5:0] M_DV  = 6'b001000;
   localparam logic [5:0] M_OE  = 6'b000111;

   typedef struct {
      int         due;
      logic [5:0] exp;
      logic [5:0] mask;
      string      req;
   } item_t;

   item_t sb[$];
   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check_item(input item_t it);
      logic [5:0] act;
      act = {crs, col, rx_dv, crs_oe, col_oe, rx_dv_oe};
      checks++;
      if ((act & it.mask) !== (it.exp & it.mask)) begin
         errors++;
         $display("FAIL %s: actual %b expected %b (mask %b) cycle %0d",
                  it.req, act & it.mask, it.exp & it.mask, it.mask, cyc);
      end
   endtask

   task automatic push(input int offset, input logic [5:0] exp, input logic [5:0] mask,
                       input string req);
      item_t it;
      it.due = cyc + 1 + offset;
      it.exp = exp;
      it.mask = mask;
      it.req = req;
      sb.push_back(it);
   endtask

   // monitor: compare every queued item on the falling edge of its due cycle
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         check_item(sb.pop_front());
      end
   end

   task automatic clear_in();
      tx_active = 0; rx_nonidle = 0; rx_pre_start = 0; rx_sfd = 0;
      rx_last = 0; tx_end_strobe = 0;
   endtask

   task automatic hb_run(input bit expect_pulse, input string req, input bit retrigger);
      int n;
      n = 2 * (D + W) + 3;
      @(negedge clk);
      clear_in();
      tx_end_strobe = 1;
      for (int k = 0; k < n; k++) begin
         push(k, {1'b0, expect_pulse && k >= D + 1 && k <= D + W, 4'b0}, M_COL, req);
      end
      for (int j = 1; j < n; j++) begin
         @(negedge clk);
         tx_end_strobe = retrigger && (j == D + 2);
      end
      @(negedge clk);
      tx_end_strobe = 0;
   endtask

   initial begin
      item_t r;
      repeat (3) @(negedge clk);
      r.due = cyc; r.exp = 6'b0; r.mask = M_ALL; r.req = "R10 reset";
      check_item(r);

      @(negedge clk); rst_n = 1; clear_in();
      push(0, 6'b000111, M_ALL, "R9 R1 idle after reset");

      @(negedge clk); tx_active = 1;
      push(0, 6'b100000, M_CRS | M_COL, "R1 tx only");
      @(negedge clk); tx_active = 0; rx_nonidle = 1;
      push(0, 6'b100000, M_CRS, "R1 rx only");
      @(negedge clk); rx_nonidle = 0;
      push(0, 6'b000000, M_CRS, "R1 both idle");

      @(negedge clk); repeater_mode = 1; tx_active = 1;
      push(0, 6'b000000, M_CRS, "R2 repeater tx only");
      @(negedge clk); rx_nonidle = 1;
      push(0, 6'b110000, M_CRS | M_COL, "R3 R2 collision repeater");
      @(negedge clk); repeater_mode = 0; full_duplex = 1;
      push(0, 6'b100000, M_CRS | M_COL, "R3 full duplex col low");
      @(negedge clk); full_duplex = 0;
      push(0, 6'b010000, M_COL, "R3 half duplex collision");
      @(negedge clk); clear_in();
      push(0, 6'b000000, M_COL | M_CRS, "R3 col drops");

      @(negedge clk); speed_100 = 1; rx_sfd = 1;
      push(0, 6'b000000, M_DV, "R6 sfd ignored fast");
      @(negedge clk); rx_sfd = 0; rx_pre_start = 1;
      push(0, 6'b001000, M_DV, "R6 preamble opens");
      @(negedge clk); rx_pre_start = 0;
      push(0, 6'b001000, M_DV, "R8 hold");
      @(negedge clk); rx_last = 1;
      push(0, 6'b000000, M_DV, "R8 last closes");
      @(negedge clk); rx_last = 0; rx_pre_start = 1;
      push(0, 6'b001000, M_DV, "R6 reopen");
      @(negedge clk); rx_pre_start = 1; rx_last = 1;
      push(0, 6'b000000, M_DV, "R8 last wins fast");

      @(negedge clk); clear_in(); speed_100 = 0; rx_pre_start = 1;
      push(0, 6'b000000, M_DV, "R7 preamble ignored slow");
      @(negedge clk); rx_pre_start = 0; rx_sfd = 1;
      push(0, 6'b001000, M_DV, "R7 sfd opens");
      @(negedge clk); rx_sfd = 1; rx_last = 1;
      push(0, 6'b000000, M_DV, "R8 last wins slow");
      @(negedge clk); clear_in();
      push(0, 6'b000000, M_DV, "R8 stays closed");

      speed_100 = 0; full_duplex = 0;
      hb_run(1'b1, "R4 R5 heartbeat window with retrigger", 1'b1);
      speed_100 = 1;
      hb_run(1'b0, "R5 no heartbeat fast", 1'b0);
      speed_100 = 0; full_duplex = 1;
      hb_run(1'b0, "R5 no heartbeat full duplex", 1'b0);
      full_duplex = 0;

      @(negedge clk); isolate = 1;
      push(0, 6'b000000, M_OE, "R9 isolate releases");
      @(negedge clk); isolate = 0;
      push(0, 6'b000111, M_OE, "R9 isolate off");

      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule